// File: doc/BRIEF.md
# Half to Single Precision Expander

This block widens a 16-bit IEEE binary16 word into the binary32 word of the same value. A producer offers half-precision words with a valid/ready handshake. The block holds each converted result in one output register, and a consumer drains that register through a second valid/ready handshake. The conversion is always exact, so the block does no rounding and raises no flags.

A per-word mode input picks between two treatments of subnormal halves. In exact mode, a subnormal half is normalised with a leading-zero count of its fraction, so it becomes the equal normal single. In flush mode, every half with a zero exponent field becomes a zero that keeps its sign. The block samples the mode together with the data word, so a mode change after a word is accepted has no effect on that word.

Control is a two-state machine. ST_EMPTY means the output register holds nothing. ST_FULL means it holds a result that has not been taken. The transitions are:
- T_LOAD: ST_EMPTY to ST_FULL when a word is accepted.
- T_STALL: ST_FULL stays in ST_FULL while the consumer is not ready.
- T_REFILL: ST_FULL stays in ST_FULL when the result is taken and a new word is accepted in the same cycle.
- T_DRAIN: ST_FULL to ST_EMPTY when the result is taken and no new word arrives.

Top module: `half_to_single_expander`

## Requirements
- R1: After reset, `res_valid` is 0 and `src_ready` is 1.
- R2: A word accepted at a clock edge (`src_valid` and `src_ready` both 1) makes `res_valid` 1 after that edge. Its result is on `res_word`.
- R3: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_word` does not change on the next cycle.
- R4: `src_ready` equals `!res_valid || res_ready`. A new word can be accepted in the same cycle that the held result is taken.
- R5: For a normal half (exponent field 1..30), the output has:
  - the sign at bit 31;
  - exponent field = input exponent + 112;
  - the 10-bit fraction at bits 22:13;
  - zeros at bits 12:0.
- R6: A half of ±0 (0x0000 or 0x8000) gives 0x00000000 or 0x80000000 in both modes.
- R7: An input with exponent field 31 and a zero fraction gives 0x7F800000, or 0xFF800000 when the sign is set.
- R8: An input with exponent field 31 and a nonzero fraction gives a NaN. The sign is kept, the exponent field is 255, fraction bits 21:13 are input fraction bits 8:0, bit 22 is 1, and bits 12:0 are 0.
- R9: In exact mode (`flush_sub`=0), a subnormal half becomes the equal normal binary32 value. Let k be the leading-zero count of the 10-bit fraction. The exponent field is 112-k, and the fraction is the input fraction shifted left by k+1, placed at bits 22:13.
- R10: In flush mode (`flush_sub`=1), a subnormal half gives a zero carrying the input sign. Normal inputs, infinities and NaNs convert as in exact mode.
- R11: Each accepted word produces exactly one result. Results leave in the order their words were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Producer offers a half word |
| src_ready | output | 1 | Block can take a word this cycle |
| src_half | input | 16 | Binary16 input word |
| flush_sub | input | 1 | 1 selects flush mode for subnormals, sampled with the word |
| res_valid | output | 1 | Output register holds a result |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_word | output | 32 | Binary32 result |

## Verification
Every result is due one clock after the edge that accepts its word. It then stays on `res_word` for as long as `res_ready` is low. `src_ready` is combinational from the current state and `res_ready`, so it is valid in the same cycle. The bench drives inputs on the falling edge and evaluates both handshakes just after it. It queues the expected binary32 value at the acceptance it predicts, and pops and compares at each predicted transfer. It also checks that `res_valid` is set on the cycle after every acceptance, and that a stalled word is unchanged one cycle later.

// File: rtl/hsx_pkg.sv
package hsx_pkg;

    localparam int H_EXP_W  = 5;
    localparam int H_FRAC_W = 10;
    localparam int S_EXP_W  = 8;
    localparam int S_FRAC_W = 23;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef enum logic {
        ST_EMPTY,
        ST_FULL
    } hold_state_e;

endpackage

// File: rtl/hsx_classify.sv
module hsx_classify
    import hsx_pkg::*;
#(
    parameter int EXP_W  = H_EXP_W,
    parameter int FRAC_W = H_FRAC_W
) (
    input  logic [EXP_W-1:0]  exp_field,
    input  logic [FRAC_W-1:0] frac_field,
    output fp_class_e         cls
);
    logic exp_all_zero;
    logic exp_all_one;
    logic frac_zero;

    assign exp_all_zero = (exp_field == '0);
    assign exp_all_one  = (exp_field == '1);
    assign frac_zero    = (frac_field == '0);

    always_comb begin
        if (exp_all_zero) begin
            cls = frac_zero ? CLS_ZERO : CLS_SUB;
        end else if (exp_all_one) begin
            cls = frac_zero ? CLS_INF : CLS_NAN;
        end else begin
            cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/hsx_lzc.sv
module hsx_lzc #(
    parameter int WIDTH = 10,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] vec,
    output logic [CNT_W-1:0] count
);
    // Prefix OR from the top: above[i] is set when any bit above i is set.
    logic [WIDTH-1:0] above;

    assign above[WIDTH-1] = 1'b0;

    genvar g;
    generate
        for (g = WIDTH - 2; g >= 0; g--) begin : g_prefix
            assign above[g] = above[g+1] | vec[g+1];
        end
    endgenerate

    // The leading-zero count equals the number of positions with nothing set
    // at or above them.
    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (!(above[i] | vec[i])) begin
                count = count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hsx_assemble.sv
module hsx_assemble
    import hsx_pkg::*;
#(
    parameter int HE = H_EXP_W,
    parameter int HF = H_FRAC_W,
    parameter int SE = S_EXP_W,
    parameter int SF = S_FRAC_W,
    localparam int H_BIAS     = (1 << (HE - 1)) - 1,
    localparam int S_BIAS     = (1 << (SE - 1)) - 1,
    localparam int BIAS_DIFF  = S_BIAS - H_BIAS,
    localparam int FRAC_SHIFT = SF - HF,
    localparam int CNT_W      = $clog2(HF + 1),
    localparam int SW         = 1 + SE + SF
) (
    input  logic              sign,
    input  logic [HE-1:0]     exp_field,
    input  logic [HF-1:0]     frac_field,
    input  fp_class_e         cls,
    input  logic              flush,
    input  logic [CNT_W-1:0]  lz,
    output logic [SW-1:0]     word
);
    logic [SE-1:0]  norm_exp;
    logic [SE-1:0]  sub_exp;
    logic [HF:0]    sub_wide;
    logic [HF-1:0]  sub_frac;
    logic [SF-1:0]  nan_frac;

    // Rebias a normal exponent.
    assign norm_exp = SE'(BIAS_DIFF) + SE'(exp_field);

    // Subnormal: shift the fraction left by lz+1 so its leading one drops
    // out as the hidden bit, and lower the exponent to match.
    assign sub_wide = {frac_field, 1'b0} << lz;
    assign sub_frac = sub_wide[HF-1:0];
    assign sub_exp  = SE'(BIAS_DIFF) - SE'(lz);

    // NaN: keep the payload in the upper fraction bits and force the quiet bit.
    always_comb begin
        nan_frac         = {frac_field, FRAC_SHIFT'(0)};
        nan_frac[SF-1]   = 1'b1;
    end

    always_comb begin
        unique case (cls)
            CLS_ZERO: word = {sign, {(SW-1){1'b0}}};
            CLS_SUB: begin
                if (flush) begin
                    word = {sign, {(SW-1){1'b0}}};
                end else begin
                    word = {sign, sub_exp, sub_frac, FRAC_SHIFT'(0)};
                end
            end
            CLS_NORM: word = {sign, norm_exp, frac_field, FRAC_SHIFT'(0)};
            CLS_INF:  word = {sign, {SE{1'b1}}, {SF{1'b0}}};
            CLS_NAN:  word = {sign, {SE{1'b1}}, nan_frac};
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/half_to_single_expander.sv
module half_to_single_expander
    import hsx_pkg::*;
#(
    parameter int HE = H_EXP_W,
    parameter int HF = H_FRAC_W,
    parameter int SE = S_EXP_W,
    parameter int SF = S_FRAC_W,
    localparam int HW    = 1 + HE + HF,
    localparam int SW    = 1 + SE + SF,
    localparam int CNT_W = $clog2(HF + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    output logic          src_ready,
    input  logic [HW-1:0] src_half,
    input  logic          flush_sub,
    output logic          res_valid,
    input  logic          res_ready,
    output logic [SW-1:0] res_word
);
    hold_state_e   state_q;
    hold_state_e   state_d;
    logic          accept;
    logic          taken;
    logic [SW-1:0] word_q;
    logic [SW-1:0] conv_word;
    fp_class_e     cls;
    logic [CNT_W-1:0] lz;

    // ---------------- datapath ----------------
    hsx_classify #(.EXP_W(HE), .FRAC_W(HF)) u_cls (
        .exp_field  (src_half[HW-2 -: HE]),
        .frac_field (src_half[HF-1:0]),
        .cls        (cls)
    );

    hsx_lzc #(.WIDTH(HF)) u_lzc (
        .vec   (src_half[HF-1:0]),
        .count (lz)
    );

    hsx_assemble #(.HE(HE), .HF(HF), .SE(SE), .SF(SF)) u_asm (
        .sign       (src_half[HW-1]),
        .exp_field  (src_half[HW-2 -: HE]),
        .frac_field (src_half[HF-1:0]),
        .cls        (cls),
        .flush      (flush_sub),
        .lz         (lz),
        .word       (conv_word)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (accept) state_d = ST_FULL;            // T_LOAD
            ST_FULL: begin
                if (taken && !accept) state_d = ST_EMPTY;       // T_DRAIN
                else                  state_d = ST_FULL;        // T_REFILL / T_STALL
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        res_valid = 1'b0;
        src_ready = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin
                res_valid = 1'b0;
                src_ready = 1'b1;
            end
            ST_FULL: begin
                res_valid = 1'b1;
                src_ready = res_ready;
            end
            default: begin
                res_valid = 1'b0;
                src_ready = 1'b1;
            end
        endcase
    end

    assign accept   = src_valid && src_ready;
    assign taken    = res_valid && res_ready;
    assign res_word = word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (accept) begin
            word_q <= conv_word;
        end
    end

    // ---------------- assertions ----------------
    p_accept_fills_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_valid);

    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_word)));

    p_backpressure_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !src_ready);

    p_nan_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_word[SW-2 -: SE] == '1) && (res_word[SF-1:0] != '0))
            |-> res_word[SF-1]);

    p_no_sub_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_word[SW-2 -: SE] == '0)) |-> (res_word[SF-1:0] == '0));

endmodule

// File: tb/sim_half_to_single_expander.sv
module sim_half_to_single_expander;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_valid = 1'b0;
    logic        src_ready;
    logic [15:0] src_half = '0;
    logic        flush_sub = 1'b0;
    logic        res_valid;
    logic        res_ready = 1'b0;
    logic [31:0] res_word;

    int vectors = 0;
    int fails   = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] lfsr = 16'hACE1;
    logic        prev_stall = 1'b0;
    logic [31:0] prev_word = '0;
    logic        prev_accept = 1'b0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    half_to_single_expander u0 (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_ready(src_ready),
        .src_half(src_half), .flush_sub(flush_sub), .res_valid(res_valid),
        .res_ready(res_ready), .res_word(res_word)
    );

    function automatic real pow2(int e);
        real r = 1.0;
        if (e >= 0) for (int i = 0; i < e; i++) r = r * 2.0;
        else        for (int i = 0; i < -e; i++) r = r / 2.0;
        return r;
    endfunction

    // Behavioural model: the value of the half, then its binary32 encoding via a double.
    function automatic logic [31:0] ref_conv(logic [15:0] h, logic fl);
        logic       s = h[15];
        int         e = int'(h[14:10]);
        int         f = int'(h[9:0]);
        real        mag;
        logic [63:0] d;
        if (e == 31) begin
            if (f == 0) return {s, 8'hFF, 23'h0};
            return {s, 8'hFF, 1'b1, h[8:0], 13'h0};
        end
        if (e == 0 && (f == 0 || fl)) return {s, 31'h0};
        if (e == 0) mag = real'(f) * pow2(-24);
        else        mag = (1.0 + real'(f) / 1024.0) * pow2(e - 15);
        d = $realtobits(mag);
        return {s, 8'(int'(d[62:52]) - 896), d[51:29]};
    endfunction

    function automatic string tag_of(logic [15:0] h, logic fl);
        if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R7" : "R8";
        if (h[14:10] == 5'd0) begin
            if (h[9:0] == 0) return "R6";
            return fl ? "R10" : "R9";
        end
        return "R5";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: got %08h expected %08h", req, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    // One cycle: drive at the falling edge, then evaluate the coming edge.
    task automatic step(logic v, logic [15:0] h, logic fl, logic rr);
        @(negedge clk);
        if (prev_accept) check("R2", 32'(res_valid), 32'd1);
        if (prev_stall) begin
            check("R3", {31'h0, res_valid}, 32'd1);
            check("R3", res_word, prev_word);
        end
        src_valid = v; src_half = h; flush_sub = fl; res_ready = rr;
        #1;
        check("R4", 32'(src_ready), 32'(!res_valid || res_ready));
        if (res_valid && res_ready) begin
            if (exp_q.size() == 0) begin
                fails++; vectors++;
                $display("FAIL R11: got %08h expected none", res_word);
            end else begin
                check({tag_of_pop(), "/R11"}, res_word, exp_q.pop_front());
            end
        end
        prev_accept = src_valid && src_ready;
        if (prev_accept) begin
            exp_q.push_back(ref_conv(h, fl));
            tag_q.push_back(tag_of(h, fl));
        end
        prev_stall = res_valid && !res_ready;
        prev_word  = res_word;
    endtask

    function automatic string tag_of_pop();
        return tag_q.pop_front();
    endfunction

    function automatic logic [15:0] next_rand(logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    logic [15:0] directed [0:16] = '{
        16'h0000, 16'h8000, 16'h3C00, 16'hC000, 16'h7BFF, 16'h0400,
        16'h0001, 16'h03FF, 16'h8200, 16'h7C00, 16'hFC00, 16'h7E00,
        16'h7C01, 16'hFD55, 16'h0155, 16'h8001, 16'h3555
    };

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", {30'h0, res_valid, src_ready}, 32'h1);
        rst_n = 1'b1;
        // Fixed expectations independent of the model (exact mode).
        step(1'b1, 16'h3C00, 1'b0, 1'b1);
        step(1'b0, 16'h0, 1'b0, 1'b0);
        check("R5", res_word, 32'h3F800000);
        step(1'b1, 16'h0001, 1'b0, 1'b1);
        step(1'b0, 16'h0, 1'b0, 1'b0);
        check("R9", res_word, 32'h33800000);
        step(1'b1, 16'h83FF, 1'b1, 1'b1);
        step(1'b0, 16'h0, 1'b0, 1'b0);
        check("R10", res_word, 32'h80000000);
        step(1'b1, 16'hFD55, 1'b0, 1'b1);
        step(1'b0, 16'h0, 1'b0, 1'b1);
        check("R8", res_word, 32'hFFEAA000);
        // Directed set, both modes, consumer always ready.
        for (int m = 0; m < 2; m++)
            foreach (directed[i]) step(1'b1, directed[i], m[0], 1'b1);
        // Directed set under back-pressure with mode toggling.
        foreach (directed[i]) begin
            lfsr = next_rand(lfsr);
            step(1'b1, directed[i], lfsr[3], lfsr[0] | lfsr[5]);
            while (!(src_valid && src_ready)) begin
                lfsr = next_rand(lfsr);
                step(1'b1, directed[i], lfsr[3], lfsr[1]);
            end
        end
        // Pseudo-random words, random valid/ready.
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] h;
            lfsr = next_rand(lfsr);
            h = lfsr ^ 16'h5A3C;
            lfsr = next_rand(lfsr);
            step(lfsr[2] | lfsr[7], h, lfsr[4], lfsr[6] | lfsr[9]);
        end
        // Drain.
        for (int n = 0; n < 4; n++) step(1'b0, 16'h0, 1'b0, 1'b1);
        check("R11", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule